// File: doc/BRIEF.md
# Timed Output Inversion Controller

This block drives a four-bit output port and, on command, flips a chosen subset of its bits once a programmable delay has run out. Software selects the bits by writing a mask to a write-only arming register. Setting the lowest mask bit starts the delay at once. The delay is counted in pulses of a clock-enable tick that stands in for a slow oscillator. When the count expires, every armed bit of the port inverts in the same cycle. The mask then clears itself, so each timed action needs a fresh write.

A busy flag covers the whole action, from the start up to one cycle after the inversion. While it is high, all register writes are dropped. A build option adds an external start-enable pin. When the option is set, a start is accepted only while that pin is high.

Top module: `tinv_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `port_out` equals the `OUT_RST` parameter (default 4'b0000) and `busy` is 0.
- R2: `rd_data` always reads 8'hFF, whatever has been written.
- R3: A write (`wr_en`=1) while `busy`=0 with `wr_data[0]`=1, and the gate satisfied, makes `busy` read 1 in the cycle after the write.
- R4: The `delay` value is captured at the start. Only ticks after the start are counted. The inversion happens on tick number `delay`+1, so a delay of 0 inverts on the first tick.
- R5: The inversion flips exactly the port bits n (n = 0..3) whose `wr_data[n]` was 1 in the starting write. Port bits whose write bit was 0 keep their value, and `wr_data[7:4]` has no effect.
- R6: `busy` falls one cycle after the cycle in which `port_out` inverts, and `port_out` never changes while `busy` is 0.
- R7: Writes made while `busy`=1 are ignored. They change neither the mask nor the delay of the running action.
- R8: A write with `wr_data[0]`=0 starts nothing and arms nothing. `busy` stays 0 and the port is never inverted by it.
- R9: With `GATE_EN`=1 (the default), a start write made while `start_pin`=0 is ignored. `busy` stays 0 and the port stays unchanged.
- R10: The arming bits clear themselves after each action. A later start inverts only the bits set in its own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the arming register |
| wr_data | input | 8 | Write data; bits 3..0 select the port bits, bit 0 also starts the timer |
| rd_data | output | 8 | Read value of the arming register (always all ones) |
| start_pin | input | 1 | External start enable; only used when `GATE_EN`=1 |
| tick | input | 1 | One-cycle clock-enable pulse that advances the delay count |
| delay | input | 8 | Delay setting in ticks, captured at the start |
| port_out | output | 4 | Output port bits |
| busy | output | 1 | High from the start until one cycle after the inversion |

## Verification
The main function is tried with several masks:
- All bits armed, which confirms that every lane flips together.
- Alternating bits, which separates lanes that flip from lanes that hold.
- A mask with the upper data bits set, which shows that those bits are dropped.

Delays of zero, three and two are used, with a tick every cycle and with a tick every fourth cycle. Together these separate a count of ticks from a count of clock cycles, and expose an off-by-one at the expiry point.

The remaining cases each start or attempt an action and then watch the port and the busy flag:
- A write made while busy, which must be ignored.
- A write with bit 0 clear, which must start nothing.
- A write with the start pin low, which must be ignored.
- A mask-only repeat after an action, which shows whether the arming bits cleared.

// File: rtl/tinv_pkg.sv
// Package: shared state encoding for the timed inversion controller.
// Assumes: nothing beyond IEEE 1800-2017.
package tinv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } tinv_state_e;
endpackage

// File: rtl/tinv_seq.sv
// Module: tinv_seq
// Sequences one timed action: accepts a start write, holds the arming mask,
// and walks idle -> run -> finish -> idle.
// Assumes: expire is a one-cycle pulse and only asserts while running.
module tinv_seq #(
    parameter int unsigned CH_N    = 4,
    parameter bit          GATE_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_N-1:0] wr_mask,
    input  logic            start_pin,
    input  logic            expire,
    output logic            busy,
    output logic            running,
    output logic            load,
    output logic [CH_N-1:0] armed
);
    import tinv_pkg::*;

    tinv_state_e state_q;
    logic        gate_ok;

    // Start gate: the pin matters only when the option is built in.
    assign gate_ok = (GATE_EN == 1'b0) || start_pin;
    assign load    = wr_en && wr_mask[0] && gate_ok && (state_q == ST_IDLE);
    assign busy    = (state_q != ST_IDLE);
    assign running = (state_q == ST_RUN);

    // State register: one action at a time, finish cycle before idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (load)   state_q <= ST_RUN;
                ST_RUN:  if (expire) state_q <= ST_FIN;
                ST_FIN:              state_q <= ST_IDLE;
                default:             state_q <= ST_IDLE;
            endcase
        end
    end

    // Arming mask: captured at start, self-cleared in the finish cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= '0;
        end else if (load) begin
            armed <= wr_mask;
        end else if (state_q == ST_FIN) begin
            armed <= '0;
        end
    end
endmodule

// File: rtl/tinv_delay_cnt.sv
// Module: tinv_delay_cnt
// Counts tick pulses against a delay captured at start; expire fires on
// the tick that finds the count equal to the captured delay.
// Assumes: load and running are never high together.
module tinv_delay_cnt #(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             running,
    input  logic             tick,
    input  logic [DLY_W-1:0] delay,
    output logic             expire
);
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] lim_q;

    // Expiry: this tick is tick number lim_q+1 since the start.
    assign expire = running && tick && (cnt_q == lim_q);

    // Count and limit registers; the count stops at the limit, so it cannot wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            lim_q <= delay;
        end else if (running && tick && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tinv_out_port.sv
// Module: tinv_out_port
// Holds the output port bits and flips the armed ones on expiry.
// Assumes: armed is stable during the expire cycle.
module tinv_out_port #(
    parameter int unsigned     CH_N    = 4,
    parameter logic [CH_N-1:0] OUT_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            expire,
    input  logic [CH_N-1:0] armed,
    output logic [CH_N-1:0] port_q
);
    // Port register: flips the armed lanes in a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= OUT_RST;
        end else if (expire) begin
            port_q <= port_q ^ armed;
        end
    end
endmodule

// File: rtl/tinv_ctrl.sv
// Module: tinv_ctrl (top)
// Timed output inversion controller: a write-only arming register, a tick
// based delay and a four-bit output port whose armed bits flip on expiry.
// Assumes: tick is a synchronous one-cycle pulse in the clk domain.
module tinv_ctrl #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned DLY_W   = 8,
    parameter bit          GATE_EN = 1'b1,
    parameter logic [3:0]  OUT_RST = 4'b0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              start_pin,
    input  logic              tick,
    input  logic [DLY_W-1:0]  delay,
    output logic [3:0]        port_out,
    output logic              busy
);
    localparam int unsigned CH_N = 4;

    logic            running;
    logic            load;
    logic            expire;
    logic [CH_N-1:0] armed;
    logic            unused_hi;

    // Read side: the arming register is write-only and reads as all ones.
    assign rd_data   = '1;
    assign unused_hi = ^wr_data[DATA_W-1:CH_N];

    tinv_seq #(.CH_N(CH_N), .GATE_EN(GATE_EN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_mask  (wr_data[CH_N-1:0]),
        .start_pin(start_pin),
        .expire   (expire),
        .busy     (busy),
        .running  (running),
        .load     (load),
        .armed    (armed)
    );

    tinv_delay_cnt #(.DLY_W(DLY_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .running(running),
        .tick   (tick),
        .delay  (delay),
        .expire (expire)
    );

    tinv_out_port #(.CH_N(CH_N), .OUT_RST(OUT_RST)) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .expire(expire),
        .armed (armed),
        .port_q(port_out)
    );
endmodule

// File: rtl/tinv_ctrl_chk.sv
// Module: tinv_ctrl_chk
// Port-level temporal checks for tinv_ctrl, attached with bind.
// Assumes: the DATA_W and GATE_EN values match those of the bound instance.
module tinv_ctrl_chk #(
    parameter int unsigned DATA_W  = 8,
    parameter bit          GATE_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              start_pin,
    input logic              tick,
    input logic [3:0]        port_out,
    input logic              busy
);
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && wr_data[0] && (!GATE_EN || start_pin)) |=> busy); // R3

    AST_NO_FLIP_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(port_out)); // R4

    AST_IDLE_PORT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(port_out)); // R6

    AST_BUSY_DROPS_AFTER_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (port_out != $past(port_out))) |=> !busy); // R6

    AST_NO_START_BIT0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(wr_en && wr_data[0])) |=> !busy); // R8

    generate
        if (GATE_EN) begin : g_gate
            AST_GATED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
                (!busy && !start_pin) |=> !busy); // R9
        end
    endgenerate
endmodule

bind tinv_ctrl tinv_ctrl_chk #(.DATA_W(DATA_W), .GATE_EN(GATE_EN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .start_pin(start_pin),
    .tick     (tick),
    .port_out (port_out),
    .busy     (busy)
);

// File: tb/tinv_ctrl_test.sv
`timescale 1ns/1ps
module tinv_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       start_pin = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] delay = '0;
    logic [3:0] port_out;
    logic       busy;

    int n_chk = 0;
    int n_fail = 0;
    int tick_per = 1;
    int tick_ctr = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_out = 0;
    int m_busy = 0;
    int m_run = 0;
    int m_fin = 0;
    int m_cnt = 0;
    int m_lim = 0;
    int m_mask = 0;

    always #4 clk = ~clk;

    tinv_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .start_pin(start_pin), .tick(tick),
        .delay(delay), .port_out(port_out), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advances once per rising edge from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 0; m_busy = 0; m_run = 0; m_fin = 0; m_cnt = 0; m_mask = 0;
        end else if (m_busy == 0) begin
            if (wr_en && wr_data[0] && start_pin) begin
                m_busy = 1; m_run = 1; m_cnt = 0;
                m_lim = int'(delay); m_mask = int'(wr_data[3:0]);
            end
        end else if (m_run == 1) begin
            if (tick) begin
                if (m_cnt == m_lim) begin
                    m_out = m_out ^ m_mask; m_run = 0; m_fin = 1;
                end else begin
                    m_cnt++;
                end
            end
        end else if (m_fin == 1) begin
            m_busy = 0; m_fin = 0; m_mask = 0;
        end
    end

    // Per-cycle comparison away from the active edge, plus tick generation
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int'(port_out) == m_out, "R4/R5 port_out", int'(port_out), m_out);
            check(int'(busy) == m_busy, "R3/R6 busy", int'(busy), m_busy);
            check(rd_data == 8'hFF, "R2 rd_data", int'(rd_data), 255);
        end
        tick <= ((tick_ctr % tick_per) == 0);
        tick_ctr++;
    end

    task automatic wr(input logic [7:0] d, input logic [7:0] dl);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; delay = dl;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        check(port_out == 4'h0, "R1 port reset", int'(port_out), 0);
        check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // All lanes, delay 0, tick every cycle
        tick_per = 1;
        wr(8'h0F, 8'd0);
        check(busy == 1'b1, "R3 busy after start", int'(busy), 1);
        @(negedge clk);
        check(port_out == 4'hF, "R4 delay 0 first tick", int'(port_out), 15);
        @(negedge clk);
        check(busy == 1'b0, "R6 busy drop", int'(busy), 0);

        // Alternating lanes, delay 3, with a write attempted while busy
        wr(8'h05, 8'd3);
        wr(8'h0B, 8'd0);
        wait_cyc(10);
        check(port_out == 4'hA, "R7 busy write ignored", int'(port_out), 10);

        // Bit 0 clear: nothing starts
        wr(8'h0E, 8'd0);
        check(busy == 1'b0, "R8 no start", int'(busy), 0);
        wait_cyc(5);
        check(port_out == 4'hA, "R8 port held", int'(port_out), 10);

        // Self-clear: a later bit-0-only write flips only lane 0
        wr(8'h01, 8'd0);
        wait_cyc(4);
        check(port_out == 4'hB, "R10 only own bits", int'(port_out), 11);

        // Gate pin low: start ignored
        start_pin = 1'b0;
        wr(8'h0F, 8'd0);
        check(busy == 1'b0, "R9 gated busy", int'(busy), 0);
        wait_cyc(5);
        check(port_out == 4'hB, "R9 gated port", int'(port_out), 11);
        start_pin = 1'b1;

        // Upper data bits set, sparse ticks, delay 2
        tick_per = 4;
        wr(8'hF3, 8'd2);
        wait_cyc(30);
        check(port_out == 4'h8, "R5 upper bits ignored", int'(port_out), 8);
        check(busy == 1'b0, "R6 idle at end", int'(busy), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule